// File: doc/BRIEF.md
# Three-Operand Accumulating ALU

This block is the arithmetic core of a small register machine. Each operation picks two operands, applies one of sixteen functions to them, and then adds a third operand. A 2-bit form field decides where the sign-extended immediate sits among the three operand positions (named `p2`, `p1`, `p0`). The function is computed as `f(p2, p1)`, and `p0` is always added on top. Because of this, one instruction can combine an operation with a constant offset or with a third register.

The datapath is purely combinational. It ends in a single result register, which has an active-low asynchronous reset. Inputs presented before a rising clock edge appear on `result_o` just after that edge. All arithmetic wraps modulo 2^32, and the block produces no flags. Instruction decode, the register file and memory are outside the block.

Top module: `tri_acc_alu`

## Requirements
- R1: For forms 0, 1 and 2, the low 12 bits of `imm_i` are sign-extended, and bits 19:12 are ignored. Form 0 gives p2=x, p1=y, p0=imm. Form 1 gives p2=x, p1=imm, p0=y. Form 2 gives p2=imm, p1=x, p0=y.
- R2: Form 3 sign-extends all 20 bits of `imm_i` into p0, sets p1=x and p2=0, and still honours the function code.
- R3: Function codes 2 (p2+p1), 11 (p2-p1) and 3 (low 32 bits of p2*p1) are each followed by +p0, and all of them wrap modulo 2^32.
- R4: Bitwise function codes are 1 AND, 9 p2&~p1, 0 OR, 4 p2|~p1 and 10 XOR, each followed by +p0.
- R5: Compare codes are 6 signed p2<p1, 7 p2==p1 and 8 signed p2>=p1. Each yields all ones when true and zero when false, before p0 is added.
- R6: Shift codes are 5 left, 13 logical right and 12 arithmetic right. Each shifts p2 by p1 read as unsigned. An amount of 32 or more gives zero for codes 5 and 13 and a copy of the sign bit for code 12. The result is then added to p0.
- R7: Code 14 yields (p2<<12) | (p1 & 0xFFF), then adds p0.
- R8: Code 15 yields all ones if bit p1 of p2 is set and zero otherwise. It yields zero whenever p1 is 32 or more. It then adds p0.
- R9: While `rst_ni` is low, `result_o` is zero. Otherwise `result_o` takes the value computed from the inputs sampled at the most recent rising edge of `clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the result register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| form_i | input | 2 | Operand placement form (0..3) |
| fn_i | input | 4 | Function code |
| x_i | input | 32 | First register operand |
| y_i | input | 32 | Second register operand |
| imm_i | input | 20 | Raw immediate |
| result_o | output | 32 | Registered result f(p2,p1)+p0 |

## Verification
The block holds state only in the result register, so any error in operand placement or in a function shows up on `result_o` one clock after the offending inputs. It does not persist into later results. The likely silent faults are a swapped slot, a wrong sign-extension width, or an off-by-one in the saturation threshold. These are caught only by operands that make the slots distinguishable (unequal x, y and immediate, including a negative immediate) and by shift or bit-index amounts of exactly 31, 32 and very large values. The bench therefore pairs directed boundary cases with a sweep over every form and code.

// File: rtl/tri_acc_alu_pkg.sv
package tri_acc_alu_pkg;
  localparam int FORM_W = 2;
  localparam int FN_W   = 4;

  typedef enum logic [FN_W-1:0] {
    FN_OR   = 4'd0,
    FN_AND  = 4'd1,
    FN_ADD  = 4'd2,
    FN_MUL  = 4'd3,
    FN_ORN  = 4'd4,
    FN_SHL  = 4'd5,
    FN_LT   = 4'd6,
    FN_EQ   = 4'd7,
    FN_GE   = 4'd8,
    FN_ANDN = 4'd9,
    FN_XOR  = 4'd10,
    FN_SUB  = 4'd11,
    FN_SAR  = 4'd12,
    FN_SHR  = 4'd13,
    FN_PACK = 4'd14,
    FN_TBIT = 4'd15
  } fn_e;

  typedef enum logic [FORM_W-1:0] {
    FORM_IMM_P0 = 2'd0,
    FORM_IMM_P1 = 2'd1,
    FORM_IMM_P2 = 2'd2,
    FORM_WIDE   = 2'd3
  } form_e;
endpackage

// File: rtl/tri_acc_alu_slots.sv
module tri_acc_alu_slots
  import tri_acc_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SMALL_W = 12,
  parameter int MED_W   = 20
) (
  input  form_e              form_i,
  input  logic [DATA_W-1:0]  x_i,
  input  logic [DATA_W-1:0]  y_i,
  input  logic [MED_W-1:0]   imm_i,
  output logic [DATA_W-1:0]  p2_o,
  output logic [DATA_W-1:0]  p1_o,
  output logic [DATA_W-1:0]  p0_o
);
  logic [DATA_W-1:0] imm_small, imm_med;

  assign imm_small = {{(DATA_W-SMALL_W){imm_i[SMALL_W-1]}}, imm_i[SMALL_W-1:0]};
  assign imm_med   = {{(DATA_W-MED_W){imm_i[MED_W-1]}}, imm_i};

  always_comb begin
    unique case (form_i)
      FORM_IMM_P0: begin p2_o = x_i;       p1_o = y_i;       p0_o = imm_small; end
      FORM_IMM_P1: begin p2_o = x_i;       p1_o = imm_small; p0_o = y_i;       end
      FORM_IMM_P2: begin p2_o = imm_small; p1_o = x_i;       p0_o = y_i;       end
      default:     begin p2_o = '0;        p1_o = x_i;       p0_o = imm_med;   end
    endcase
  end
endmodule

// File: rtl/tri_acc_alu_shift.sv
module tri_acc_alu_shift #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [DATA_W-1:0] amt_i,
  input  logic              left_i,
  input  logic              arith_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0]         pre, post;
  logic [SH_W:0][DATA_W-1:0] stg;
  logic                      fill, oob;

  // left shifts reuse the right-shift network on bit-reversed data
  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      pre[i] = left_i ? val_i[DATA_W-1-i] : val_i[i];
  end

  assign fill   = arith_i & ~left_i & val_i[DATA_W-1];
  assign stg[0] = pre;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stg[k+1] = amt_i[k] ? {{S{fill}}, stg[k][DATA_W-1:S]} : stg[k];
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      post[i] = left_i ? stg[SH_W][DATA_W-1-i] : stg[SH_W][i];
  end

  // amounts >= DATA_W saturate to a full fill
  assign oob   = |amt_i[DATA_W-1:SH_W];
  assign res_o = oob ? {DATA_W{fill}} : post;
endmodule

// File: rtl/tri_acc_alu_func.sv
module tri_acc_alu_func
  import tri_acc_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PACK_W = 12
) (
  input  fn_e               fn_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] f_o
);
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sh_res, pack_res;
  logic              bit_hit;

  tri_acc_alu_shift #(.DATA_W(DATA_W)) u_shift (
    .val_i   (a_i),
    .amt_i   (b_i),
    .left_i  (fn_i == FN_SHL),
    .arith_i (fn_i == FN_SAR),
    .res_o   (sh_res)
  );

  assign bit_hit  = ~|b_i[DATA_W-1:SH_W] & a_i[b_i[SH_W-1:0]];
  assign pack_res = {a_i[DATA_W-PACK_W-1:0], b_i[PACK_W-1:0]};

  always_comb begin
    unique case (fn_i)
      FN_OR:   f_o = a_i | b_i;
      FN_AND:  f_o = a_i & b_i;
      FN_ADD:  f_o = a_i + b_i;
      FN_MUL:  f_o = a_i * b_i;
      FN_ORN:  f_o = a_i | ~b_i;
      FN_ANDN: f_o = a_i & ~b_i;
      FN_XOR:  f_o = a_i ^ b_i;
      FN_SUB:  f_o = a_i - b_i;
      FN_LT:   f_o = {DATA_W{$signed(a_i) <  $signed(b_i)}};
      FN_EQ:   f_o = {DATA_W{a_i == b_i}};
      FN_GE:   f_o = {DATA_W{$signed(a_i) >= $signed(b_i)}};
      FN_SHL, FN_SHR, FN_SAR: f_o = sh_res;
      FN_PACK: f_o = pack_res;
      default: f_o = {DATA_W{bit_hit}};
    endcase
  end
endmodule

// File: rtl/tri_acc_alu.sv
module tri_acc_alu
  import tri_acc_alu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int SMALL_W   = 12,
  parameter int MED_W     = 20,
  parameter int PACK_W    = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        form_i,
  input  logic [3:0]        fn_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [MED_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] p2, p1, p0, fval, sum;

  tri_acc_alu_slots #(
    .DATA_W(DATA_W), .SMALL_W(SMALL_W), .MED_W(MED_W)
  ) u_slots (
    .form_i (form_e'(form_i)),
    .x_i    (x_i),
    .y_i    (y_i),
    .imm_i  (imm_i),
    .p2_o   (p2),
    .p1_o   (p1),
    .p0_o   (p0)
  );

  tri_acc_alu_func #(
    .DATA_W(DATA_W), .PACK_W(PACK_W)
  ) u_func (
    .fn_i (fn_e'(fn_i)),
    .a_i  (p2),
    .b_i  (p1),
    .f_o  (fval)
  );

  assign sum = fval + p0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) result_o <= '0;
    else         result_o <= sum;
  end
endmodule

// File: rtl/tri_acc_alu_chk.sv
module tri_acc_alu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        form_i,
  input logic [3:0]        fn_i,
  input logic [DATA_W-1:0] x_i,
  input logic [DATA_W-1:0] y_i,
  input logic [DATA_W-1:0] p2_i,
  input logic [DATA_W-1:0] p1_i,
  input logic [DATA_W-1:0] p0_i,
  input logic [DATA_W-1:0] fval_i,
  input logic [DATA_W-1:0] result_i
);
  logic past_ok;
  logic p1_big;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assign p1_big = p1_i >= DATA_W;

  a_r1_form0_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
    form_i == 2'd0 |-> (p2_i == x_i && p1_i == y_i));

  a_r1_form2_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
    form_i == 2'd2 |-> (p1_i == x_i && p0_i == y_i));

  a_r2_wide_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
    form_i == 2'd3 |-> (p2_i == '0 && p1_i == x_i));

  a_r5_cmp_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_i inside {4'd6, 4'd7, 4'd8}) |-> (fval_i == '0 || fval_i == '1));

  a_r6_shift_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fn_i == 4'd5 || fn_i == 4'd13) && p1_big) |-> fval_i == '0);

  a_r6_sar_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_i == 4'd12 && p1_big) |-> fval_i == {DATA_W{p2_i[DATA_W-1]}});

  a_r8_tbit_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_i == 4'd15 && p1_big) |-> fval_i == '0);

  a_r9_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> result_i == '0);

  a_r9_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> result_i == $past(fval_i + p0_i));
endmodule

bind tri_acc_alu tri_acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .form_i   (form_i),
  .fn_i     (fn_i),
  .x_i      (x_i),
  .y_i      (y_i),
  .p2_i     (p2),
  .p1_i     (p1),
  .p0_i     (p0),
  .fval_i   (fval),
  .result_i (result_o)
);

// File: tb/tri_acc_alu_bench.sv
`timescale 1ns/1ps
module tri_acc_alu_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  form_i = '0;
  logic [3:0]  fn_i = '0;
  logic [31:0] x_i = '0, y_i = '0;
  logic [19:0] imm_i = '0;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #4 clk_i = ~clk_i;

  tri_acc_alu u_tri_acc_alu (
    .clk_i, .rst_ni, .form_i, .fn_i, .x_i, .y_i, .imm_i, .result_o
  );

  function automatic logic [31:0] model(input logic [1:0] t, input logic [3:0] op,
                                        input logic [31:0] x, input logic [31:0] y,
                                        input logic [19:0] imm);
    logic [31:0] s12, s20, a, b, c, f;
    s12 = {{20{imm[11]}}, imm[11:0]};
    s20 = {{12{imm[19]}}, imm};
    case (t)
      2'd0: begin a = x;   b = y;   c = s12; end
      2'd1: begin a = x;   b = s12; c = y;   end
      2'd2: begin a = s12; b = x;   c = y;   end
      default: begin a = 0; b = x;  c = s20; end
    endcase
    case (op)
      4'd0:  f = a | b;
      4'd1:  f = a & b;
      4'd2:  f = a + b;
      4'd3:  f = a * b;
      4'd4:  f = a | ~b;
      4'd5:  f = (b < 32) ? a << b[4:0] : 32'd0;
      4'd6:  f = ($signed(a) < $signed(b)) ? 32'hFFFF_FFFF : 32'd0;
      4'd7:  f = (a == b) ? 32'hFFFF_FFFF : 32'd0;
      4'd8:  f = ($signed(a) >= $signed(b)) ? 32'hFFFF_FFFF : 32'd0;
      4'd9:  f = a & ~b;
      4'd10: f = a ^ b;
      4'd11: f = a - b;
      4'd12: f = (b < 32) ? 32'($signed(a) >>> b[4:0]) : {32{a[31]}};
      4'd13: f = (b < 32) ? a >> b[4:0] : 32'd0;
      4'd14: f = (a << 12) | (b & 32'hFFF);
      default: f = (b < 32 && a[b[4:0]]) ? 32'hFFFF_FFFF : 32'd0;
    endcase
    return f + c;
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd2, 4'd3, 4'd11:        return "R3";
      4'd0, 4'd1, 4'd4, 4'd9, 4'd10: return "R4";
      4'd6, 4'd7, 4'd8:         return "R5";
      4'd5, 4'd12, 4'd13:       return "R6";
      4'd14:                    return "R7";
      default:                  return "R8";
    endcase
  endfunction

  task automatic drive(input logic [1:0] t, input logic [3:0] op, input logic [31:0] x,
                       input logic [31:0] y, input logic [19:0] imm, input string tag);
    @(negedge clk_i);
    form_i = t; fn_i = op; x_i = x; y_i = y; imm_i = imm;
    exp_q.push_back(model(t, op, x, y, imm));
    tag_q.push_back(tag);
  endtask

  // monitor: each queued item is due just after the next rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (exp_q.size() > 0) begin
        logic [31:0] e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        checks++;
        if (result_o !== e) begin
          errors++;
          $display("FAIL %s: result %h expected %h", tg, result_o, e);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    x_i = 32'hDEAD_BEEF; y_i = 32'h1234_5678; fn_i = 4'd2; imm_i = 20'h00123;
    repeat (3) @(posedge clk_i);
    #2;
    checks++;
    if (result_o !== 32'd0) begin
      errors++;
      $display("FAIL R9: reset result %h expected %h", result_o, 32'd0);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 slot placement, negative and upper-bit-polluted immediates
    drive(2'd0, 4'd2,  32'd100, 32'd20,   20'h00FFF, "R1");
    drive(2'd1, 4'd11, 32'd50,  32'd7,    20'h00003, "R1");
    drive(2'd2, 4'd11, 32'd5,   32'd1000, 20'h0000A, "R1");
    drive(2'd0, 4'd2,  32'd1,   32'd2,    20'hABC05, "R1");
    drive(2'd2, 4'd14, 32'h0000_0ABC, 32'd0, 20'hFF801, "R1");
    // R2 wide immediate
    drive(2'd3, 4'd0,  32'h0000_00F0, 32'h5555_5555, 20'h80000, "R2");
    drive(2'd3, 4'd2,  32'h0000_0010, 32'd9, 20'h7FFFF, "R2");
    drive(2'd3, 4'd11, 32'd3, 32'd0, 20'h00001, "R2");
    // R3 wrap
    drive(2'd0, 4'd2,  32'h7FFF_FFFF, 32'd1, 20'h0, "R3");
    drive(2'd0, 4'd3,  32'h0001_0000, 32'h0001_0000, 20'h00005, "R3");
    drive(2'd0, 4'd11, 32'd0, 32'd1, 20'h0, "R3");
    // R4
    drive(2'd0, 4'd4,  32'h0F0F_0000, 32'hFFFF_0000, 20'h0, "R4");
    drive(2'd0, 4'd9,  32'hFFFF_FFFF, 32'h00FF_00FF, 20'h00001, "R4");
    // R5 signed compares
    drive(2'd0, 4'd6,  32'hFFFF_FFFF, 32'd1, 20'h0, "R5");
    drive(2'd0, 4'd6,  32'd1, 32'hFFFF_FFFF, 20'h0, "R5");
    drive(2'd0, 4'd8,  32'd7, 32'd7, 20'h00002, "R5");
    drive(2'd0, 4'd7,  32'd7, 32'd8, 20'h00002, "R5");
    drive(2'd0, 4'd7,  32'd9, 32'd9, 20'h0, "R5");
    // R6 shift limits
    drive(2'd0, 4'd5,  32'h0000_0001, 32'd31, 20'h0, "R6");
    drive(2'd0, 4'd5,  32'h0000_0001, 32'd32, 20'h0, "R6");
    drive(2'd0, 4'd13, 32'h8000_0000, 32'd31, 20'h0, "R6");
    drive(2'd0, 4'd13, 32'h8000_0000, 32'd32, 20'h00003, "R6");
    drive(2'd0, 4'd12, 32'h8000_0000, 32'd40, 20'h0, "R6");
    drive(2'd0, 4'd12, 32'h4000_0000, 32'hFFFF_FFFF, 20'h0, "R6");
    drive(2'd0, 4'd12, 32'h8000_0000, 32'd4, 20'h0, "R6");
    // R7 pack
    drive(2'd0, 4'd14, 32'h1234_5678, 32'hFFFF_FABC, 20'h00010, "R7");
    // R8 bit test
    drive(2'd0, 4'd15, 32'h8000_0000, 32'd31, 20'h0, "R8");
    drive(2'd0, 4'd15, 32'hFFFF_FFFF, 32'd32, 20'h0, "R8");
    drive(2'd0, 4'd15, 32'hFFFF_FFFF, 32'd63, 20'h00007, "R8");
    drive(2'd0, 4'd15, 32'hFFFF_FFFE, 32'd0, 20'h0, "R8");

    // sweep every form and function code
    for (int op = 0; op < 16; op++) begin
      for (int t = 0; t < 4; t++) begin
        for (int n = 0; n < 8; n++) begin
          logic [31:0] xr, yr;
          xr = $urandom();
          yr = (n < 4) ? ($urandom() % 40) : $urandom();
          drive(2'(t), 4'(op), xr, yr, 20'($urandom()), tag_of(4'(op)));
        end
      end
    end

    // R9: result follows each new input after one edge
    drive(2'd0, 4'd0, 32'h0000_00AA, 32'h0000_5500, 20'h0, "R9");
    drive(2'd0, 4'd0, 32'h0000_0001, 32'h0000_0002, 20'h0, "R9");

    repeat (3) @(posedge clk_i);
    #3;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule